// File: doc/BRIEF.md
# Page Write Buffer with Self-Timed Commit

This block sits between a serial memory's bus front end and its storage array. The front end hands it a starting word address and then a stream of received data bytes. The block places each byte into a sixteen-slot page latch at the slot named by the low four bits of an internal address counter. After each byte it steps only those four bits, so the counter wraps inside the current page and never crosses into the next one. A per-slot valid mask records which slots have been loaded.

When the front end reports the stop event that ends a write transfer, and at least one slot is loaded, the block starts a self-timed write cycle. It raises `busy` for exactly `WR_TICKS` clock cycles. During the first cycles of that window it copies each loaded slot to the array, one write strobe per cycle, in rising slot order. At the end of the window it clears the mask and drops `busy`. While `busy` is high, every request from the front end is ignored. An address-byte match (`dev_sel`) gets no acknowledge, so the host can poll for completion. The array is an ordinary synchronous RAM that takes `arr_we`, `arr_addr` and `arr_wdata`.

Top module: `page_write_buffer`

## Requirements
- R1: Out of reset, `busy`, `arr_we` and `sel_ack` are 0 and `next_addr` is 0.
- R2: When idle and not in a stop cycle, `addr_ld` loads `next_addr` from `addr_in`. `addr_ld` wins over a `byte_vld` in the same cycle. Each accepted byte is stored in slot `next_addr[3:0]`. That field then steps by one modulo 16, and bits [10:4] stay unchanged.
- R3: If more than 16 bytes arrive before stop, the slot index wraps. A later byte replaces the earlier content of the same slot, and only the last value reaches the array.
- R4: A stop taken while idle with at least one loaded slot raises `busy` on the next clock edge. `busy` then stays high for exactly `WR_TICKS` cycles.
- R5: During a write cycle, `arr_we` pulses once for each loaded slot and for no other slot, in increasing slot order. The address is {`next_addr[10:4]`, slot} and the data is the latched byte. Slot k is written in busy cycle k+2, counting the first busy cycle as 1.
- R6: A stop with no loaded slot, such as one after an address-only transfer, starts no cycle. `busy` and `arr_we` stay 0.
- R7: While `busy` is high, `addr_ld`, `byte_vld` and `stop` have no effect. `next_addr` holds, and no byte offered then is ever written.
- R8: `sel_ack` is 1 in the cycle after `dev_sel` exactly when `busy` was 0 at that edge.
- R9: When the cycle ends, the valid mask is empty, so a following stop starts nothing. `next_addr` keeps the last loaded address plus one, wrapped within its page.
- R10: A byte presented in the same cycle as `stop` is dropped. It is neither latched nor counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_ld | input | 1 | Load start word address |
| addr_in | input | ADDR_W | Start word address |
| byte_vld | input | 1 | Received data byte strobe |
| byte_data | input | DATA_W | Received data byte |
| stop | input | 1 | Stop event ending the transfer |
| dev_sel | input | 1 | Address byte matched; acknowledge requested |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | DATA_W | Array write data |
| busy | output | 1 | Write cycle in progress |
| sel_ack | output | 1 | Acknowledge for `dev_sel` |
| next_addr | output | ADDR_W | Address counter |

## Verification
`busy` and `sel_ack` change one clock edge after the stop or select that causes them. The slot-k array write appears k+1 edges after that, and `busy` falls `WR_TICKS` edges after it rose. Inputs are driven and outputs sampled on falling edges, so every check reads the value settled after the rising edge that should have produced it. A scoreboard queue is filled at each stop from a bench-side page model. The monitor counts busy cycles to check both the cycle in which each write strobe appears and the total length of the busy window.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_COPY   = 2'd1,
    SQ_SETTLE = 2'd2
  } seq_state_t;
endpackage

// File: rtl/pwb_addr_ctr.sv
module pwb_addr_ctr #(
  parameter int ADDR_W = 11,
  parameter int OFS_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              inc,
  output logic [ADDR_W-1:0] addr_q
);
  localparam int PAGE_W = ADDR_W - OFS_W;

  logic [OFS_W-1:0]  ofs_q;
  logic [PAGE_W-1:0] page_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ofs_q  <= '0;
      page_q <= '0;
    end else if (ld) begin
      ofs_q  <= ld_addr[OFS_W-1:0];
      page_q <= ld_addr[ADDR_W-1:OFS_W];
    end else if (inc) begin
      ofs_q  <= ofs_q + 1'b1;
    end
  end

  assign addr_q = {page_q, ofs_q};

  // R2: stepping never leaves the page
  a_r2_page_fixed: assert property (@(posedge clk) disable iff (rst)
    ($past(inc) && !$past(ld)) |-> (addr_q[ADDR_W-1:OFS_W] == $past(addr_q[ADDR_W-1:OFS_W])));
endmodule

// File: rtl/pwb_latch.sv
module pwb_latch #(
  parameter int DATA_W = 8,
  parameter int SLOTS  = 16,
  parameter int OFS_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [OFS_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [OFS_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  input  logic              clr_mask,
  output logic [SLOTS-1:0]  mask
);
  logic [DATA_W-1:0] mem [SLOTS];

  // single memory, write when collecting, registered read when copying
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= mem[rd_idx];
  end

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst || clr_mask)
        mask[i] <= 1'b0;
      else if (wr_en && (wr_idx == OFS_W'(i)))
        mask[i] <= 1'b1;
    end
  end

  // R7: the latch is never written while it is being copied out
  a_r7_no_wr_in_copy: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && rd_en));
endmodule

// File: rtl/pwb_seq.sv
module pwb_seq
  import pwb_pkg::*;
#(
  parameter int WR_TICKS = 1000,
  parameter int SLOTS    = 16,
  parameter int OFS_W    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  output logic             busy,
  output logic             rd_en,
  output logic [OFS_W-1:0] slot,
  output logic             done
);
  localparam int CNT_W = $clog2(WR_TICKS);
  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(SLOTS - 1);
  localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(WR_TICKS - 1);

  seq_state_t       state;
  logic [CNT_W-1:0] cnt;

  initial assert (WR_TICKS > SLOTS);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SQ_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        SQ_IDLE: begin
          cnt <= '0;
          if (launch) state <= SQ_COPY;
        end
        SQ_COPY: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST_SLOT) state <= SQ_SETTLE;
        end
        SQ_SETTLE: begin
          if (done) begin
            state <= SQ_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign busy  = (state != SQ_IDLE);
  assign rd_en = (state == SQ_COPY);
  assign slot  = cnt[OFS_W-1:0];
  assign done  = (state == SQ_SETTLE) && (cnt == LAST_TICK);

  // R4: a cycle starts only on a launch request
  a_r4_rise_on_launch: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(launch));
  // R4: the closing tick ends the busy window
  a_r4_done_ends: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);
endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer #(
  parameter int ADDR_W   = 11,
  parameter int DATA_W   = 8,
  parameter int SLOTS    = 16,
  parameter int WR_TICKS = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_ld,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              stop,
  input  logic              dev_sel,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata,
  output logic              busy,
  output logic              sel_ack,
  output logic [ADDR_W-1:0] next_addr
);
  localparam int OFS_W = $clog2(SLOTS);

  logic             accept, ld_acc, byte_acc, launch;
  logic             rd_en, done;
  logic [OFS_W-1:0] slot;
  logic [SLOTS-1:0] mask;

  assign accept   = !busy && !stop;
  assign ld_acc   = addr_ld && accept;
  assign byte_acc = byte_vld && accept && !addr_ld;
  assign launch   = stop && !busy && (|mask);

  pwb_addr_ctr #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_ctr (
    .clk(clk), .rst(rst), .ld(ld_acc), .ld_addr(addr_in),
    .inc(byte_acc), .addr_q(next_addr)
  );

  pwb_latch #(.DATA_W(DATA_W), .SLOTS(SLOTS), .OFS_W(OFS_W)) u_latch (
    .clk(clk), .rst(rst), .wr_en(byte_acc), .wr_idx(next_addr[OFS_W-1:0]),
    .wr_data(byte_data), .rd_en(rd_en), .rd_idx(slot), .rd_data(arr_wdata),
    .clr_mask(done), .mask(mask)
  );

  pwb_seq #(.WR_TICKS(WR_TICKS), .SLOTS(SLOTS), .OFS_W(OFS_W)) u_seq (
    .clk(clk), .rst(rst), .launch(launch), .busy(busy),
    .rd_en(rd_en), .slot(slot), .done(done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      arr_we   <= 1'b0;
      arr_addr <= '0;
      sel_ack  <= 1'b0;
    end else begin
      arr_we   <= rd_en && mask[slot];
      arr_addr <= {next_addr[ADDR_W-1:OFS_W], slot};
      sel_ack  <= dev_sel && !busy;
    end
  end

  // R5: array strobes only inside the busy window
  a_r5_we_in_busy: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> busy);
  // R6: never start with an empty latch
  a_r6_needs_data: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(|mask));
  // R7: counter frozen while busy
  a_r7_addr_hold: assert property (@(posedge clk) disable iff (rst)
    busy |-> $stable(next_addr));
  // R8: acknowledge only for a select seen while idle
  a_r8_ack_idle: assert property (@(posedge clk) disable iff (rst)
    sel_ack |-> ($past(dev_sel) && !$past(busy)));
endmodule

// File: tb/page_write_buffer_test.sv
module page_write_buffer_test;
  localparam int AW = 11;
  localparam int DW = 8;
  localparam int T  = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic addr_ld = 1'b0, byte_vld = 1'b0, stop = 1'b0, dev_sel = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [DW-1:0] byte_data = '0;
  logic arr_we, busy, sel_ack;
  logic [AW-1:0] arr_addr, next_addr;
  logic [DW-1:0] arr_wdata;

  always #2.5 clk = ~clk;

  page_write_buffer #(.ADDR_W(AW), .DATA_W(DW), .SLOTS(16), .WR_TICKS(T)) uut (
    .clk(clk), .rst(rst), .addr_ld(addr_ld), .addr_in(addr_in),
    .byte_vld(byte_vld), .byte_data(byte_data), .stop(stop), .dev_sel(dev_sel),
    .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
    .busy(busy), .sel_ack(sel_ack), .next_addr(next_addr)
  );

  int checks = 0;
  int errors = 0;
  logic [AW+DW-1:0] exp_q[$];
  logic [DW-1:0] blat [16];
  logic [15:0]   bmask = '0;
  logic [AW-1:0] baddr = '0;
  int run = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected writes, measures the busy window
  always @(negedge clk) begin
    if (!rst) begin
      if (busy) run = run + 1;
      if (arr_we) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R5 unexpected write", {13'd0, arr_addr, arr_wdata}, 32'd0);
        end else begin
          logic [AW+DW-1:0] e;
          e = exp_q.pop_front();
          check({arr_addr, arr_wdata} == e, "R5 write addr/data", {13'd0, arr_addr, arr_wdata}, {13'd0, e});
          check(run == int'(arr_addr[3:0]) + 2, "R5 write cycle", run, int'(arr_addr[3:0]) + 2);
        end
      end
      if (!busy && run > 0) begin
        check(run == T, "R4 busy length", run, T);
        check(exp_q.size() == 0, "R5 all loaded slots written", exp_q.size(), 0);
        run = 0;
      end
    end
  end

  task automatic load(input logic [AW-1:0] a);
    @(negedge clk); addr_ld = 1'b1; addr_in = a;
    @(negedge clk); addr_ld = 1'b0;
    baddr = a;
  endtask

  task automatic put(input logic [DW-1:0] d);
    @(negedge clk); byte_vld = 1'b1; byte_data = d;
    @(negedge clk); byte_vld = 1'b0;
    blat[baddr[3:0]] = d;
    bmask[baddr[3:0]] = 1'b1;
    baddr[3:0] = baddr[3:0] + 4'd1;
  endtask

  // stop, optionally with a byte in the same cycle (R10: byte dropped)
  task automatic fire(input bit with_byte, input logic [DW-1:0] d);
    bit had;
    @(negedge clk); stop = 1'b1; byte_vld = with_byte; byte_data = d;
    had = (bmask != 0);
    if (had) begin
      for (int i = 0; i < 16; i++)
        if (bmask[i]) exp_q.push_back({baddr[AW-1:4], 4'(i), blat[i]});
      bmask = '0;
    end
    @(negedge clk); stop = 1'b0; byte_vld = 1'b0;
    if (had) check(busy == 1'b1, "R4 busy after stop", busy, 1);
    else     check(busy == 1'b0, "R6 no cycle on empty stop", busy, 0);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic poll(input bit exp_ack);
    dev_sel = 1'b1;
    @(negedge clk); dev_sel = 1'b0;
    check(sel_ack == exp_ack, "R8 select acknowledge", sel_ack, exp_ack);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check(busy == 0 && arr_we == 0 && sel_ack == 0, "R1 reset outputs", {busy, arr_we, sel_ack}, 0);
    check(next_addr == 0, "R1 reset counter", next_addr, 0);

    // R2 basic page write
    load(11'h123);
    check(next_addr == 11'h123, "R2 address load", next_addr, 11'h123);
    put(8'h11); put(8'h22); put(8'h33);
    check(next_addr == 11'h126, "R2 counter step", next_addr, 11'h126);
    fire(1'b0, 8'h00);
    poll(1'b0);
    // R7: requests during busy are ignored
    addr_ld = 1'b1; addr_in = 11'h555;
    @(negedge clk); addr_ld = 1'b0; byte_vld = 1'b1; byte_data = 8'hEE;
    @(negedge clk); byte_vld = 1'b0; stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    wait_idle();
    check(next_addr == 11'h126, "R7/R9 counter kept", next_addr, 11'h126);
    poll(1'b1);
    // R9: mask empty after cycle, a new stop starts nothing
    fire(1'b0, 8'h00);
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R9 mask cleared", busy, 0);

    // R3 wrap within page
    load(11'h7FA);
    for (int i = 0; i < 20; i++) put(8'(8'h40 + i));
    check(next_addr == 11'h7FE, "R3 wrap keeps page", next_addr, 11'h7FE);
    fire(1'b0, 8'h00);
    wait_idle();

    // R6 dummy write: address only
    load(11'h040);
    fire(1'b0, 8'h00);
    repeat (4) @(negedge clk);
    check(busy == 1'b0 && arr_we == 1'b0, "R6 dummy write idle", {busy, arr_we}, 0);

    // R10 byte with stop dropped
    load(11'h200);
    put(8'hAA);
    fire(1'b1, 8'hBB);
    wait_idle();
    check(next_addr == 11'h201, "R10 byte with stop dropped", next_addr, 11'h201);

    // full page
    load(11'h3B0);
    for (int i = 0; i < 16; i++) put(8'(8'hC0 ^ i));
    check(next_addr == 11'h3B0, "R2 full page wraps to start", next_addr, 11'h3B0);
    fire(1'b0, 8'h00);
    wait_idle();
    @(negedge clk);
    check(exp_q.size() == 0, "R5 scoreboard empty", exp_q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule